// File: doc/BRIEF.md
# Quantized Legendre Memory Recurrent Cell

This block computes one step of a recurrent memory cell for each incoming feature frame, using one shared multiply-accumulate unit that a small sequencer walks through three phases. First a scalar drive is formed from the current input and last frame's hidden vector. Next the memory vector is advanced through fixed, non-trainable recurrence and input coefficients. Last the hidden vector is produced from the current input and the freshly updated memory, through a ReLU.

The trainable encoders, weights and biases are loaded through a simple write port before frames are streamed in. The memory and hidden state carry over from frame to frame. Only the global reset clears them, so the cell always continues from whatever audio it has recently seen. Every activation is a 7-bit signed value, which lets each product with a 4-bit weight fit an 8-bit signed multiplier. At one frame every 20 ms, a step of a few dozen cycles leaves ample slack even with a clock below 100 kHz.

Top module: `lmu_cell`

## Requirements
- R1: The drive is u = sat(( Σi ex[i]·x[i] + Σj eh[j]·h_prev[j] ) >>> SHIFT), where h_prev is the hidden vector published by the previous step.
- R2: Memory row i becomes sat(( Σj A(i,j)·m_old[j] + B(i)·u ) >>> SHIFT). The fixed coefficients are A(i,i)=6, A(i,j)=−1 for j>i, A(i,j)=+1 for i>j with (i−j) even and −1 with (i−j) odd, and B(i)=+2 for even i and −2 for odd i.
- R3: Hidden unit r is max(0, sat(( bias[r] + Σi wx[r][i]·x[i] + Σj wm[r][j]·m_new[j] ) >>> SHIFT)), using the memory produced in the same step, so every published hidden element lies in 0..63.
- R4: Every shift is arithmetic on a 24-bit signed sum, and saturation clamps the result to −64..63.
- R5: Encoders and weights use only the low 4 bits of their stored byte as a signed value (−8..7); a zero weight contributes nothing. The bias is the whole byte as a signed value and is added before the shift.
- R6: Write addresses, with defaults IN_DIM=3, MEM_ORD=4, HID_UNITS=3: ex at 0..2, eh at 3..5, wx[r][i] at 6+r·IN_DIM+i, wm[r][j] at 15+r·MEM_ORD+j, bias[r] at 27+r. Writes to 30 and above are dropped.
- R7: Memory and hidden state persist between frames. Reset clears them, along with all weights and the overrun flag.
- R8: `step_done` is high for exactly one cycle, IN_DIM+HID_UNITS+MEM_ORD·(MEM_ORD+1)+HID_UNITS·(IN_DIM+MEM_ORD)+1 cycles after the edge that accepts a frame (48 with the defaults). `h_out` changes only in that cycle.
- R9: A frame strobe that arrives while a step is running is ignored and sets a sticky overrun flag.
- R10: The drive of a step reads only the hidden vector that the previous step published, never values that the running step is producing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| cfg_we | input | 1 | Weight write strobe |
| cfg_addr | input | ADDR_W | Weight write address (map in R6) |
| cfg_data | input | 8 | Weight write data |
| frame_valid | input | 1 | Start a step with the frame on `x_in` |
| x_in | input | IN_DIM·7 | Feature vector; element i at bits [7i+6:7i], signed |
| h_out | output | HID_UNITS·7 | Hidden vector; unit r at bits [7r+6:7r] |
| step_done | output | 1 | One-cycle pulse when `h_out` holds a new result |
| overrun | output | 1 | Sticky flag: a frame arrived while busy |

## Verification
The hardest situation to reach is a frame strobe that lands in the middle of a step. The bench raises the strobe a chosen number of cycles after acceptance. It then checks that the step still produces the single-frame result, that no second completion follows, and that the flag stays set. The saturation rails are just as hard to reach from ordinary features, so dedicated weight sets drive every sum past +63 and below −64, and these are checked against a bench-side model. The persistence and previous-hidden dependence are covered by streaming a table of frames, including repeated zero frames whose outputs differ only because of carried state.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  parameter int ACT_W = 7;
  parameter int WGT_W = 4;
  parameter int OPW   = 8;
  parameter int ACC_W = 24;

  typedef logic signed [ACT_W-1:0] act_t;
  typedef logic signed [OPW-1:0]   opw_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic [2:0] {PH_IDLE, PH_DRIVE, PH_MEMORY, PH_HIDDEN, PH_DONE} phase_e;

  localparam acc_t ACT_HI = acc_t'((1 <<< (ACT_W-1)) - 1);
  localparam acc_t ACT_LO = acc_t'(-(1 <<< (ACT_W-1)));

  function automatic acc_t ashr(input acc_t v, input int sh);
    return v >>> sh;
  endfunction

  function automatic act_t sat_act(input acc_t v);
    if (v > ACT_HI) return act_t'(ACT_HI);
    if (v < ACT_LO) return act_t'(ACT_LO);
    return v[ACT_W-1:0];
  endfunction

  function automatic act_t relu_act(input act_t v);
    return v[ACT_W-1] ? '0 : v;
  endfunction

  // low nibble of a stored byte, sign extended to multiplier width
  function automatic opw_t wgt_ext(input logic [OPW-1:0] raw);
    logic signed [WGT_W-1:0] n;
    n = raw[WGT_W-1:0];
    return opw_t'(n);
  endfunction

  function automatic opw_t fixed_a(input int i, input int j);
    if (i == j) return opw_t'(6);
    if (j > i) return opw_t'(-1);
    return (((i - j) % 2) == 1) ? opw_t'(-1) : opw_t'(1);
  endfunction

  function automatic opw_t fixed_b(input int i);
    return ((i % 2) == 0) ? opw_t'(2) : opw_t'(-2);
  endfunction
endpackage

// File: rtl/lmu_wbank.sv
module lmu_wbank #(
  parameter int NW     = 30,
  parameter int ADDR_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DW-1:0]     rdata_a,
  output logic [DW-1:0]     rdata_b
);
  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NW; i++)
        if (i == int'(waddr)) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NW; i++) begin
      if (i == int'(raddr_a)) rdata_a = mem[i];
      if (i == int'(raddr_b)) rdata_b = mem[i];
    end
  end
endmodule

// File: rtl/lmu_mac.sv
module lmu_mac
  import lmu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  logic bias_en,
  input  opw_t w,
  input  act_t a,
  input  opw_t bias,
  output acc_t sum
);
  logic signed [OPW+ACT_W-1:0] prod;
  acc_t acc_q, base;

  assign prod = w * a;

  always_comb begin
    if (first) base = bias_en ? acc_t'(bias) : '0;
    else       base = acc_q;
    sum = base + acc_t'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum;
  end
endmodule

// File: rtl/lmu_seq.sv
module lmu_seq
  import lmu_pkg::*;
#(
  parameter int IN_DIM    = 3,
  parameter int MEM_ORD   = 4,
  parameter int HID_UNITS = 3,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  output phase_e        phase,
  output logic [CW-1:0] row,
  output logic [CW-1:0] term,
  output logic          first_term,
  output logic          last_term,
  output logic          active,
  output logic          accept,
  output logic          busy,
  output logic          copy_en,
  output logic          done
);
  int n_terms, n_rows;
  logic last_row;
  phase_e nxt_phase;

  always_comb begin
    n_terms = 1; n_rows = 1; nxt_phase = PH_IDLE;
    unique case (phase)
      PH_DRIVE:  begin n_terms = IN_DIM + HID_UNITS; n_rows = 1;         nxt_phase = PH_MEMORY; end
      PH_MEMORY: begin n_terms = MEM_ORD + 1;        n_rows = MEM_ORD;   nxt_phase = PH_HIDDEN; end
      PH_HIDDEN: begin n_terms = IN_DIM + MEM_ORD;   n_rows = HID_UNITS; nxt_phase = PH_DONE;   end
      default:   ;
    endcase
  end

  assign active     = (phase == PH_DRIVE) || (phase == PH_MEMORY) || (phase == PH_HIDDEN);
  assign busy       = (phase != PH_IDLE);
  assign accept     = (phase == PH_IDLE) && frame_valid;
  assign copy_en    = (phase == PH_DONE);
  assign first_term = (term == '0);
  assign last_term  = (int'(term) == n_terms - 1);
  assign last_row   = (int'(row) == n_rows - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      row   <= '0;
      term  <= '0;
      done  <= 1'b0;
    end else begin
      done <= copy_en;
      if (accept) begin
        phase <= PH_DRIVE;
        row   <= '0;
        term  <= '0;
      end else if (copy_en) begin
        phase <= PH_IDLE;
      end else if (active) begin
        if (last_term) begin
          term <= '0;
          if (last_row) begin
            row   <= '0;
            phase <= nxt_phase;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          term <= term + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lmu_cell.sv
module lmu_cell
  import lmu_pkg::*;
#(
  parameter int IN_DIM    = 3,
  parameter int MEM_ORD   = 4,
  parameter int HID_UNITS = 3,
  parameter int SHIFT     = 3,
  parameter int NWORDS    = IN_DIM + HID_UNITS + HID_UNITS*IN_DIM + HID_UNITS*MEM_ORD + HID_UNITS,
  parameter int ADDR_W    = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [7:0]                 cfg_data,
  input  logic                       frame_valid,
  input  logic [IN_DIM*ACT_W-1:0]    x_in,
  output logic [HID_UNITS*ACT_W-1:0] h_out,
  output logic                       step_done,
  output logic                       overrun
);
  localparam int EX_BASE = 0;
  localparam int EH_BASE = EX_BASE + IN_DIM;
  localparam int WX_BASE = EH_BASE + HID_UNITS;
  localparam int WM_BASE = WX_BASE + HID_UNITS*IN_DIM;
  localparam int B_BASE  = WM_BASE + HID_UNITS*MEM_ORD;
  localparam int MAXN0   = (IN_DIM + HID_UNITS > MEM_ORD + 1) ? IN_DIM + HID_UNITS : MEM_ORD + 1;
  localparam int MAXN1   = (IN_DIM + MEM_ORD > MAXN0) ? IN_DIM + MEM_ORD : MAXN0;
  localparam int MAXN    = (HID_UNITS > MAXN1) ? HID_UNITS : MAXN1;
  localparam int CW      = $clog2(MAXN + 1);

  phase_e phase;
  logic [CW-1:0] row, term;
  logic first_term, last_term, active, accept, busy, copy_en;
  logic [ADDR_W-1:0] rd_a_addr, rd_b_addr;
  logic [7:0] rd_a, rd_b;
  opw_t w_op;
  act_t a_op;
  logic bias_en;
  acc_t mac_sum;
  act_t res;

  act_t x_w [IN_DIM];
  act_t x_q [IN_DIM];
  act_t u_q;
  act_t m_q [MEM_ORD];
  act_t m_nxt [MEM_ORD];
  act_t h_q [HID_UNITS];
  act_t h_nxt [HID_UNITS];

  for (genvar i = 0; i < IN_DIM; i++) begin : g_xin
    assign x_w[i] = x_in[i*ACT_W +: ACT_W];
  end
  for (genvar r = 0; r < HID_UNITS; r++) begin : g_hout
    assign h_out[r*ACT_W +: ACT_W] = h_q[r];
  end

  lmu_seq #(.IN_DIM(IN_DIM), .MEM_ORD(MEM_ORD), .HID_UNITS(HID_UNITS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .phase(phase), .row(row),
    .term(term), .first_term(first_term), .last_term(last_term), .active(active),
    .accept(accept), .busy(busy), .copy_en(copy_en), .done(step_done));

  lmu_wbank #(.NW(NWORDS), .ADDR_W(ADDR_W), .DW(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_data),
    .raddr_a(rd_a_addr), .raddr_b(rd_b_addr), .rdata_a(rd_a), .rdata_b(rd_b));

  lmu_mac u_mac (
    .clk(clk), .rst_n(rst_n), .en(active), .first(first_term), .bias_en(bias_en),
    .w(w_op), .a(a_op), .bias(opw_t'(rd_b)), .sum(mac_sum));

  assign res = sat_act(ashr(mac_sum, SHIFT));

  // operand selection for the shared multiplier
  always_comb begin
    int rr, kk;
    rr = int'(row);
    kk = int'(term);
    rd_a_addr = '0;
    rd_b_addr = '0;
    w_op      = '0;
    a_op      = '0;
    bias_en   = 1'b0;
    unique case (phase)
      PH_DRIVE: begin
        if (kk < IN_DIM) begin
          rd_a_addr = ADDR_W'(EX_BASE + kk);
          for (int i = 0; i < IN_DIM; i++) if (i == kk) a_op = x_q[i];
        end else begin
          rd_a_addr = ADDR_W'(EH_BASE + kk - IN_DIM);
          for (int j = 0; j < HID_UNITS; j++) if (j == kk - IN_DIM) a_op = h_q[j];
        end
        w_op = wgt_ext(rd_a);
      end
      PH_MEMORY: begin
        if (kk < MEM_ORD) begin
          w_op = fixed_a(rr, kk);
          for (int j = 0; j < MEM_ORD; j++) if (j == kk) a_op = m_q[j];
        end else begin
          w_op = fixed_b(rr);
          a_op = u_q;
        end
      end
      PH_HIDDEN: begin
        bias_en   = 1'b1;
        rd_b_addr = ADDR_W'(B_BASE + rr);
        if (kk < IN_DIM) begin
          rd_a_addr = ADDR_W'(WX_BASE + rr*IN_DIM + kk);
          for (int i = 0; i < IN_DIM; i++) if (i == kk) a_op = x_q[i];
        end else begin
          rd_a_addr = ADDR_W'(WM_BASE + rr*MEM_ORD + kk - IN_DIM);
          for (int j = 0; j < MEM_ORD; j++) if (j == kk - IN_DIM) a_op = m_nxt[j];
        end
        w_op = wgt_ext(rd_a);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IN_DIM; i++) x_q[i] <= '0;
      for (int j = 0; j < MEM_ORD; j++) begin m_q[j] <= '0; m_nxt[j] <= '0; end
      for (int r = 0; r < HID_UNITS; r++) begin h_q[r] <= '0; h_nxt[r] <= '0; end
      u_q     <= '0;
      overrun <= 1'b0;
    end else begin
      if (frame_valid && busy) overrun <= 1'b1;
      if (accept) x_q <= x_w;
      if (active && last_term) begin
        unique case (phase)
          PH_DRIVE:  u_q <= res;
          PH_MEMORY: for (int j = 0; j < MEM_ORD; j++) if (j == int'(row)) m_nxt[j] <= res;
          PH_HIDDEN: for (int r = 0; r < HID_UNITS; r++) if (r == int'(row)) h_nxt[r] <= relu_act(res);
          default: ;
        endcase
      end
      if (copy_en) begin
        m_q <= m_nxt;
        h_q <= h_nxt;
      end
    end
  end
endmodule

// File: rtl/lmu_cell_chk.sv
module lmu_cell_chk #(
  parameter int IN_DIM    = 3,
  parameter int MEM_ORD   = 4,
  parameter int HID_UNITS = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_valid,
  input logic                   step_done,
  input logic                   overrun,
  input logic [HID_UNITS*7-1:0] h_out,
  input logic                   busy,
  input logic                   accept
);
  localparam int LAT = IN_DIM + HID_UNITS + MEM_ORD*(MEM_ORD+1) + HID_UNITS*(IN_DIM+MEM_ORD) + 1;

  logic [15:0] since_accept;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_accept <= '0;
    else if (accept)                 since_accept <= '0;
    else if (since_accept != '1)     since_accept <= since_accept + 1'b1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (int'(since_accept) == LAT));
  assert_h_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_out) |-> step_done);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && busy) |=> overrun);

  for (genvar r = 0; r < HID_UNITS; r++) begin : g_relu
    assert_hidden_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !h_out[r*7+6]);
  end
endmodule

bind lmu_cell lmu_cell_chk #(.IN_DIM(IN_DIM), .MEM_ORD(MEM_ORD), .HID_UNITS(HID_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .step_done(step_done),
  .overrun(overrun), .h_out(h_out), .busy(busy), .accept(accept));

// File: tb/tb_lmu_cell.sv
module tb_lmu_cell;
  localparam int IN = 3, MO = 4, HU = 3, SH = 3;
  localparam int NW = IN + HU + HU*IN + HU*MO + HU;
  localparam int AW = $clog2(NW);
  localparam int LAT = IN + HU + MO*(MO+1) + HU*(IN+MO) + 1;
  localparam int NF = 8;
  // stimulus frames; expected hidden vectors come from the step model below
  localparam int FR [NF][IN] = '{
    '{10, -5, 3}, '{63, 63, 63}, '{-64, -64, -64}, '{0, 0, 0},
    '{1, 2, 3}, '{-20, 40, -7}, '{0, 0, 0}, '{33, -33, 12}};

  logic clk = 0, rst_n = 0, cfg_we = 0, frame_valid = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [IN*7-1:0] x_in = '0;
  logic [HU*7-1:0] h_out;
  logic step_done, overrun;

  int n_chk = 0, n_fail = 0;
  int wt [NW];
  int mm [MO], hh [HU], cx [IN];

  lmu_cell dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .frame_valid(frame_valid), .x_in(x_in), .h_out(h_out),
    .step_done(step_done), .overrun(overrun));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nib(input int raw);  return ((raw & 15) ^ 8) - 8;   endfunction
  function automatic int byt(input int raw);  return ((raw & 255) ^ 128) - 128; endfunction
  function automatic int clamp(input int v);  return v > 63 ? 63 : (v < -64 ? -64 : v); endfunction
  function automatic int coef_a(input int i, input int j);
    if (i == j) return 6;
    if (i < j) return -1;
    return ((i - j) & 1) ? -1 : 1;
  endfunction
  function automatic int coef_b(input int i); return (i & 1) ? -2 : 2; endfunction

  function automatic longint pack_h();
    longint p = 0;
    for (int r = 0; r < HU; r++) p |= longint'(hh[r] & 127) << (7*r);
    return p;
  endfunction

  task automatic model_step();
    int s, u;
    int mn [MO];
    int hn [HU];
    s = 0;
    for (int i = 0; i < IN; i++) s += nib(wt[i]) * cx[i];
    for (int j = 0; j < HU; j++) s += nib(wt[IN+j]) * hh[j];
    u = clamp(s >>> SH);
    for (int r = 0; r < MO; r++) begin
      s = coef_b(r) * u;
      for (int j = 0; j < MO; j++) s += coef_a(r, j) * mm[j];
      mn[r] = clamp(s >>> SH);
    end
    for (int r = 0; r < HU; r++) begin
      s = byt(wt[IN+HU+HU*IN+HU*MO+r]);
      for (int i = 0; i < IN; i++) s += nib(wt[IN+HU+r*IN+i]) * cx[i];
      for (int j = 0; j < MO; j++) s += nib(wt[IN+HU+HU*IN+r*MO+j]) * mn[j];
      hn[r] = clamp(s >>> SH);
      if (hn[r] < 0) hn[r] = 0;
    end
    mm = mn;
    hh = hn;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_data = 8'(d);
    if (a < NW) wt[a] = d & 255;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_frame(input int ovr_at, output int lat, output int dones);
    @(negedge clk);
    for (int i = 0; i < IN; i++) x_in[i*7 +: 7] = 7'(cx[i]);
    frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
    lat = 0; dones = 0;
    while (dones == 0 && lat < 2000) begin
      @(negedge clk);
      lat++;
      frame_valid = (lat == ovr_at);
      if (step_done) dones++;
    end
    frame_valid = 0;
    if (dones == 0) chk(0, "R8 watchdog", lat, LAT);
    model_step();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int a = 0; a < NW; a++) wt[a] = 0;
    for (int j = 0; j < MO; j++) mm[j] = 0;
    for (int r = 0; r < HU; r++) hh[r] = 0;
  endtask

  initial begin
    #4000000;
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat, dn, extra;
    do_reset();
    // R7: reset state
    chk(h_out == '0 && !step_done && !overrun, "R7 reset state", h_out, 0);

    // R6 R5: weight pattern with pruned zeros and junk in the upper nibble
    for (int a = 0; a < NW; a++)
      wr(a, (a % 5 == 0) ? 0 : ((a * 7 + 3) % 16) | (((a * 3) % 16) << 4));
    wr(NW + 1, 8'h55);  // R6: outside the map, dropped

    // R1 R2 R3 R7 R10: stream the frame table through the cell
    for (int f = 0; f < NF; f++) begin
      for (int i = 0; i < IN; i++) cx[i] = FR[f][i];
      run_frame(-1, lat, dn);
      chk(lat == LAT, "R8 latency", lat, LAT);
      chk(longint'(h_out) == pack_h(), "R1 R2 R3 R10 frame result", h_out, pack_h());
    end
    @(negedge clk);
    chk(step_done == 0, "R8 single-cycle done", step_done, 0);

    // R4: positive rail, every weight +7, bias +127
    for (int a = 0; a < NW; a++) wr(a, (a >= NW - HU) ? 8'h7F : 8'hF7);
    for (int i = 0; i < IN; i++) cx[i] = 63;
    run_frame(-1, lat, dn);
    chk(longint'(h_out) == pack_h(), "R4 upper saturation", h_out, pack_h());
    chk(hh[0] == 63, "R4 model reaches +63", hh[0], 63);

    // R4 R3: negative rail, every weight -8, ReLU floors the output
    for (int a = 0; a < NW; a++) wr(a, (a >= NW - HU) ? 8'h80 : 8'h08);
    run_frame(-1, lat, dn);
    chk(longint'(h_out) == pack_h(), "R4 R3 lower saturation", h_out, pack_h());

    // R5: all weights zero, only bias matters in this step
    for (int a = 0; a < NW; a++) wr(a, (a >= NW - HU) ? 8'h28 : 8'hF0);
    run_frame(-1, lat, dn);
    chk(longint'(h_out) == pack_h(), "R5 zero weights", h_out, pack_h());
    chk(hh[0] == 5, "R5 bias only", hh[0], 5);

    // R9: strobe mid-step is ignored and latched in overrun
    for (int a = 0; a < NW; a++) wr(a, (a * 11 + 5) & 255);
    for (int i = 0; i < IN; i++) cx[i] = 17 - 9*i;
    chk(overrun == 0, "R9 flag clear before", overrun, 0);
    run_frame(20, lat, dn);
    chk(longint'(h_out) == pack_h(), "R9 result unaffected", h_out, pack_h());
    chk(lat == LAT, "R9 latency unaffected", lat, LAT);
    extra = 0;
    for (int c = 0; c < LAT + 10; c++) begin @(negedge clk); if (step_done) extra++; end
    chk(extra == 0, "R9 no second step", extra, 0);
    chk(overrun == 1, "R9 sticky overrun", overrun, 1);

    // R7: reset clears state, weights and flag
    do_reset();
    chk(h_out == '0 && overrun == 0, "R7 cleared by reset", {overrun, h_out}, 0);
    for (int i = 0; i < IN; i++) cx[i] = 40;
    run_frame(-1, lat, dn);
    chk(h_out == '0, "R7 weights cleared", h_out, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule